// File: doc/BRIEF.md
# Multiplexed Bus Latch Transceiver

This block joins one shared A bus to two banked B buses, 1B and 2B. It can merge two data paths onto one path, or split one path into two. Typical uses are a bus that carries address and data on the same wires, and memory interleaving across two banks.

Four storage elements sit between the ports, and each has its own capture enable. Two of them carry the A word toward 1B and toward 2B. The other two carry the 1B word and the 2B word back toward A. A select input decides which of the two B-side words appears on A.

Each port has its own active-low output enable. In the A-to-B direction, the two B enables steer a write to one bank, to the other bank, or to both.

Bidirectional pins are split into three parts: an input vector, an output vector and an output-enable bit. The pin driver itself lives outside this block.

Each storage element is a register sampled on `clk_i` with a transparent bypass. While its enable is high, the output equals the input in the same cycle. Once the enable is low, the output holds the input value from the last clock edge at which the enable was high.

Top module: `mux_bus_latch`

## Requirements
- R1: After `rst_ni` is released, with every capture enable low, all four stored words are zero, so `a_o`, `b1_o` and `b2_o` read zero.
- R2: While a capture enable is high, its output follows its input in the same cycle with no clock delay. `cap_a_b1_i` passes `a_i` to `b1_o`. `cap_a_b2_i` passes `a_i` to `b2_o`. `cap_b1_a_i` and `cap_b2_a_i` feed `b1_i` and `b2_i` into the A-side selection.
- R3: After a capture enable goes low, its output holds the input value sampled at the last rising clock edge at which the enable was high. Later changes on that input have no effect on the output.
- R4: The two A-to-B words are independent. Capturing into one bank leaves the word held for the other bank unchanged.
- R5: `sel_b1_i` = 1 drives `a_o` from the 1B-side word, and `sel_b1_i` = 0 drives it from the 2B-side word. Switching the select changes `a_o` in the same cycle and changes neither stored word.
- R6: The output-enable outputs are the inverse of the active-low enables: `a_oe_o` = !`oe_a_ni`, `b1_oe_o` = !`oe_b1_ni`, `b2_oe_o` = !`oe_b2_ni`. Each one is independent of the other two. A data output is only defined while its enable output is 1.
- R7: Raising both A-to-B enables together writes the same A word into both banks.
- R8: The A-to-B and B-to-A words are independent. Capture activity in one direction leaves the words held for the other direction unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sampling clock for the storage registers |
| rst_ni | input | 1 | Asynchronous active-low reset, clears stored words |
| a_i | input | 12 | Word arriving on the A bus |
| b1_i | input | 12 | Word arriving on the 1B bus |
| b2_i | input | 12 | Word arriving on the 2B bus |
| cap_a_b1_i | input | 1 | Capture enable, A toward 1B |
| cap_a_b2_i | input | 1 | Capture enable, A toward 2B |
| cap_b1_a_i | input | 1 | Capture enable, 1B toward A |
| cap_b2_a_i | input | 1 | Capture enable, 2B toward A |
| sel_b1_i | input | 1 | A source select: 1 = 1B-side word, 0 = 2B-side word |
| oe_a_ni | input | 1 | Active-low output enable for the A bus |
| oe_b1_ni | input | 1 | Active-low output enable for the 1B bus |
| oe_b2_ni | input | 1 | Active-low output enable for the 2B bus |
| a_o | output | 12 | Word driven onto the A bus |
| a_oe_o | output | 1 | A bus drive enable |
| b1_o | output | 12 | Word driven onto the 1B bus |
| b1_oe_o | output | 1 | 1B bus drive enable |
| b2_o | output | 12 | Word driven onto the 2B bus |
| b2_oe_o | output | 1 | 2B bus drive enable |

## Verification
The bench walks every combination of the four capture enables, the select and the output enables while the data words change each cycle. It predicts every output from a model that only stores a word at edges where its enable was high.

Several faults would show up under this sweep:
- A swapped select polarity, or swapped bank wiring, puts the wrong bank's word on `a_o` or `b1_o`.
- A storage element that samples on the wrong enable level, or that lacks the bypass, shows a stale word while open, or a moving word while closed.
- Cross-coupled enables corrupt the idle bank or the opposite direction, and targeted sequences for R4, R7 and R8 catch this.
- An uninverted output enable fails on every step.

// File: rtl/mbl_pkg.sv
package mbl_pkg;
  localparam int unsigned DATA_W = 12;
  localparam int unsigned N_BANK = 2;
endpackage

// File: rtl/mbl_latch.sv
// Transparent latch built as a sampled register plus bypass.
module mbl_latch #(
  parameter int unsigned W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   hold_q <= '0;
    else if (en_i) hold_q <= d_i;
  end

  assign q_o = en_i ? d_i : hold_q;
endmodule

// File: rtl/mbl_a_mux.sv
module mbl_a_mux #(
  parameter int unsigned W = 12
) (
  input  logic         sel_b1_i,
  input  logic [W-1:0] from_b1_i,
  input  logic [W-1:0] from_b2_i,
  output logic [W-1:0] a_o
);
  always_comb begin
    if (sel_b1_i) a_o = from_b1_i;
    else          a_o = from_b2_i;
  end
endmodule

// File: rtl/mux_bus_latch.sv
module mux_bus_latch #(
  parameter int unsigned W = mbl_pkg::DATA_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b1_i,
  input  logic [W-1:0] b2_i,
  input  logic         cap_a_b1_i,
  input  logic         cap_a_b2_i,
  input  logic         cap_b1_a_i,
  input  logic         cap_b2_a_i,
  input  logic         sel_b1_i,
  input  logic         oe_a_ni,
  input  logic         oe_b1_ni,
  input  logic         oe_b2_ni,
  output logic [W-1:0] a_o,
  output logic         a_oe_o,
  output logic [W-1:0] b1_o,
  output logic         b1_oe_o,
  output logic [W-1:0] b2_o,
  output logic         b2_oe_o
);
  localparam int unsigned NB = mbl_pkg::N_BANK;

  logic [NB-1:0]        fwd_en, rev_en;
  logic [W-1:0]         rev_d   [NB];
  logic [W-1:0]         fwd_q   [NB];
  logic [W-1:0]         rev_q   [NB];

  assign fwd_en   = {cap_a_b2_i, cap_a_b1_i};
  assign rev_en   = {cap_b2_a_i, cap_b1_a_i};
  assign rev_d[0] = b1_i;
  assign rev_d[1] = b2_i;

  // one forward and one reverse storage element per bank
  for (genvar g = 0; g < NB; g++) begin : g_bank
    mbl_latch #(.W(W)) u_fwd (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (fwd_en[g]),
      .d_i   (a_i),
      .q_o   (fwd_q[g])
    );
    mbl_latch #(.W(W)) u_rev (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .en_i  (rev_en[g]),
      .d_i   (rev_d[g]),
      .q_o   (rev_q[g])
    );
  end

  mbl_a_mux #(.W(W)) u_a_mux (
    .sel_b1_i (sel_b1_i),
    .from_b1_i(rev_q[0]),
    .from_b2_i(rev_q[1]),
    .a_o      (a_o)
  );

  assign b1_o    = fwd_q[0];
  assign b2_o    = fwd_q[1];
  assign a_oe_o  = ~oe_a_ni;
  assign b1_oe_o = ~oe_b1_ni;
  assign b2_oe_o = ~oe_b2_ni;
endmodule

// File: rtl/mux_bus_latch_chk.sv
module mux_bus_latch_chk #(
  parameter int unsigned W = 12
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic [W-1:0] a_i,
  input logic [W-1:0] b1_i,
  input logic [W-1:0] b2_i,
  input logic         cap_a_b1_i,
  input logic         cap_a_b2_i,
  input logic         cap_b1_a_i,
  input logic         cap_b2_a_i,
  input logic         sel_b1_i,
  input logic         oe_a_ni,
  input logic         oe_b1_ni,
  input logic         oe_b2_ni,
  input logic [W-1:0] a_o,
  input logic         a_oe_o,
  input logic [W-1:0] b1_o,
  input logic         b1_oe_o,
  input logic [W-1:0] b2_o,
  input logic         b2_oe_o
);
  // R2
  open_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_b1_i |-> b1_o == a_i);
  // R2
  open_b2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_a_b2_i |-> b2_o == a_i);
  // R3
  capture_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cap_a_b1_i) |-> b1_o == $past(a_i));
  // R3
  hold_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_a_b1_i && $past(!cap_a_b1_i)) |-> $stable(b1_o));
  // R4
  hold_b2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cap_a_b2_i && $past(!cap_a_b2_i)) |-> $stable(b2_o));
  // R5
  sel_b1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_b1_i && cap_b1_a_i) |-> a_o == b1_i);
  // R5
  sel_b2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_b1_i && cap_b2_a_i) |-> a_o == b2_i);
  // R6
  oe_pol_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (a_oe_o != oe_a_ni) && (b1_oe_o != oe_b1_ni) && (b2_oe_o != oe_b2_ni));
endmodule

bind mux_bus_latch mux_bus_latch_chk #(.W(W)) chk_i (.*);

// File: tb/mux_bus_latch_tb.sv
module mux_bus_latch_tb_top;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] a_i = '0, b1_i = '0, b2_i = '0;
  logic         c_ab1 = 0, c_ab2 = 0, c_b1a = 0, c_b2a = 0, sel = 0;
  logic         oea_n = 0, oeb1_n = 0, oeb2_n = 0;
  logic [W-1:0] a_o, b1_o, b2_o;
  logic         a_oe, b1_oe, b2_oe;

  logic [W-1:0] m_ab1 = '0, m_ab2 = '0, m_b1a = '0, m_b2a = '0;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  mux_bus_latch #(.W(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .a_i(a_i), .b1_i(b1_i), .b2_i(b2_i),
    .cap_a_b1_i(c_ab1), .cap_a_b2_i(c_ab2), .cap_b1_a_i(c_b1a), .cap_b2_a_i(c_b2a),
    .sel_b1_i(sel), .oe_a_ni(oea_n), .oe_b1_ni(oeb1_n), .oe_b2_ni(oeb2_n),
    .a_o(a_o), .a_oe_o(a_oe), .b1_o(b1_o), .b1_oe_o(b1_oe), .b2_o(b2_o), .b2_oe_o(b2_oe)
  );

  task automatic check(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, check mid-cycle, update model after posedge
  task automatic step(logic [W-1:0] a, logic [W-1:0] b1, logic [W-1:0] b2,
                      logic [3:0] caps, logic s, logic [2:0] oen);
    logic [W-1:0] e_b1a, e_b2a;
    @(negedge clk);
    a_i = a; b1_i = b1; b2_i = b2;
    {c_b2a, c_b1a, c_ab2, c_ab1} = caps;
    sel = s;
    {oeb2_n, oeb1_n, oea_n} = oen;
    #5;
    e_b1a = c_b1a ? b1 : m_b1a;
    e_b2a = c_b2a ? b2 : m_b2a;
    check("R6", {11'd0, a_oe},  {11'd0, ~oea_n});
    check("R6", {11'd0, b1_oe}, {11'd0, ~oeb1_n});
    check("R6", {11'd0, b2_oe}, {11'd0, ~oeb2_n});
    if (!oeb1_n) check(c_ab1 ? "R2" : "R3", b1_o, c_ab1 ? a : m_ab1);
    if (!oeb2_n) check(c_ab2 ? "R2" : "R4", b2_o, c_ab2 ? a : m_ab2);
    if (!oea_n)  check("R5", a_o, s ? e_b1a : e_b2a);
    @(posedge clk);
    #1;
    if (c_ab1) m_ab1 = a;
    if (c_ab2) m_ab2 = a;
    if (c_b1a) m_b1a = b1;
    if (c_b2a) m_b2a = b2;
  endtask

  initial begin
    #(20 * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    // R1: cleared storage after reset
    check("R1", b1_o, '0);
    check("R1", b2_o, '0);
    sel = 1; #1; check("R1", a_o, '0);
    sel = 0; #1; check("R1", a_o, '0);

    // R7: both banks capture the same word
    step(12'hA5C, 12'h111, 12'h222, 4'b0011, 1'b0, 3'b000);
    step(12'h3F0, 12'h333, 12'h444, 4'b0000, 1'b0, 3'b000);
    check("R7", b1_o, 12'hA5C);
    check("R7", b2_o, 12'hA5C);

    // R4: capture into 1B only leaves 2B word
    step(12'h0F1, 12'h000, 12'h000, 4'b0001, 1'b0, 3'b000);
    step(12'h777, 12'h000, 12'h000, 4'b0000, 1'b0, 3'b000);
    check("R4", b2_o, 12'hA5C);
    check("R4", b1_o, 12'h0F1);

    // R8: reverse captures leave forward words untouched
    step(12'hFFF, 12'hB1B, 12'hB2B, 4'b1100, 1'b1, 3'b000);
    step(12'h000, 12'h000, 12'h000, 4'b0000, 1'b1, 3'b000);
    check("R8", b1_o, 12'h0F1);
    check("R8", b2_o, 12'hA5C);
    check("R5", a_o, 12'hB1B);
    // R5: select toggle changes a_o only
    step(12'h000, 12'h000, 12'h000, 4'b0000, 1'b0, 3'b000);
    check("R5", a_o, 12'hB2B);

    // sweep all enable, select and output-enable combinations
    for (int i = 0; i < 1024; i++) begin
      step(W'((i * 37 + 5) % 4096), W'((i * 91 + 300) % 4096), W'((i * 173 + 77) % 4096),
           4'(i % 16), 1'((i / 16) % 2), 3'((i / 32) % 8));
    end
    // R3: hold while inputs keep moving
    for (int i = 0; i < 64; i++) begin
      step(W'(i * 59), W'(i * 61), W'(i * 67), 4'b0000, 1'(i % 2), 3'b000);
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule